// File: doc/BRIEF.md
# Reset Control Port

This block is a one-byte register at a fixed I/O port. Software writes it to ask for a system reset. It sits on a simple register bus made of a byte address, a write-data word, a byte-enable mask, a write strobe, a read strobe and a read-data word. Only byte lane 0 of the data word carries the register.

A write that sets the trigger bit (bit 2) produces a single-clock reset-request pulse, and the stored byte keeps its value. A write with the trigger bit clear stores the reset-type bit (bit 1) and forces every other stored bit to zero. The stored byte can be read back. The reset-type bit also drives an output for the platform's reset sequencer, which is outside this block.

Top module: `sysreset_ctl`

## Requirements
- R1: The register responds only when the 16-bit byte address equals 0x0CF9; no other address value selects it.
- R2: A selected, lane-0-enabled write with write-data bit 2 set drives `rst_req` high for exactly the clock cycle after the write edge. Each such write gives one pulse, and `rst_req` is low at all other times.
- R3: A selected, enabled write with write-data bit 2 set leaves the stored byte unchanged.
- R4: A selected, enabled write with write-data bit 2 clear stores write-data bit 1 at bit 1 and zero in bits 7..3, 2 and 0, starting at the write edge.
- R5: A selected read returns the stored byte on read-data bits 7..0 in the same cycle as the read strobe, with bits 31..8 at zero; bit 2 therefore always reads as 0.
- R6: While reset is asserted, and after it is released, the stored byte is 0x00 and `rst_req` is low.
- R7: Writes to any other address change neither the stored byte nor `rst_req`, and reads of any other address return zero.
- R8: A write to 0x0CF9 with byte-enable bit 0 low is ignored: the stored byte keeps its value and no request pulse occurs, whatever the other enable bits are.
- R9: `rst_type` always equals bit 1 of the stored byte.
- R10: Read data is zero whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O byte address |
| io_wdata | input | 32 | Write data; lane 0 carries the register |
| io_be | input | 4 | Byte enables; only bit 0 qualifies a write |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 32 | Read data, combinational from the read strobe |
| rst_req | output | 1 | One-cycle reset-request pulse |
| rst_type | output | 1 | Stored reset-type bit |

## Verification
Each result has a fixed latency:
- Read data is valid in the same cycle as the read strobe.
- The stored byte and `rst_type` take their new value at the edge that samples the write.
- `rst_req` rises at that same edge and falls at the next one.

The bench drives on the falling edge and samples one nanosecond after a rising edge, which lands between the edge that does the work and the next one. It checks the pulse in the cycle after the write and checks that it is gone one cycle later. Reads are sampled within the low half of the clock while the strobe is held.

// File: rtl/sysreset_ctl_pkg.sv
package sysreset_ctl_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned TRIG_BIT = 2;
  localparam int unsigned TYPE_BIT = 1;
  localparam logic [REG_W-1:0] KEEP_MASK = REG_W'(1) << TYPE_BIT;

  // byte lane 0 of a wider data word
  function automatic logic [REG_W-1:0] lane0(input logic [31:0] word);
    return word[REG_W-1:0];
  endfunction

  function automatic logic is_trigger(input logic [REG_W-1:0] b);
    return b[TRIG_BIT];
  endfunction

  // value retained by a non-trigger write
  function automatic logic [REG_W-1:0] kept_value(input logic [REG_W-1:0] b);
    return b & KEEP_MASK;
  endfunction
endpackage

// File: rtl/sysreset_ctl_decode.sv
module sysreset_ctl_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic              be_lane0,
  output logic              hit,
  output logic              wr_ok,
  output logic              rd_ok
);
  always_comb begin
    hit   = (addr == PORT_ADDR);
    wr_ok = hit && wr && be_lane0;
    rd_ok = hit && rd;
  end
endmodule

// File: rtl/sysreset_ctl_store.sv
module sysreset_ctl_store
  import sysreset_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic [REG_W-1:0] wbyte,
  output logic [REG_W-1:0] stored,
  output logic             trig_ev,
  output logic             keep_ev
);
  always_comb begin
    trig_ev = wr_ok && is_trigger(wbyte);
    keep_ev = wr_ok && !is_trigger(wbyte);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stored <= '0;
    else if (keep_ev) stored <= kept_value(wbyte);
  end

  AST_TRIG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ev |=> $stable(stored)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(stored)); // R7
  AST_KEEP_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    keep_ev |=> stored[TYPE_BIT] == $past(wbyte[TYPE_BIT])); // R4
endmodule

// File: rtl/sysreset_ctl_pulse.sv
module sysreset_ctl_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_ev,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= trig_ev;
  end

  AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ev |=> req); // R2
  AST_REQ_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(trig_ev)); // R2
endmodule

// File: rtl/sysreset_ctl.sv
module sysreset_ctl
  import sysreset_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9,
  localparam int unsigned BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic [BE_W-1:0]   io_be,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [DATA_W-1:0] io_rdata,
  output logic              rst_req,
  output logic              rst_type
);
  logic             hit, wr_ok, rd_ok, trig_ev, keep_ev;
  logic [REG_W-1:0] stored;
  logic [REG_W-1:0] wbyte;

  assign wbyte = lane0(io_wdata[31:0]);

  sysreset_ctl_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr(io_addr), .wr(io_wr), .rd(io_rd), .be_lane0(io_be[0]),
    .hit(hit), .wr_ok(wr_ok), .rd_ok(rd_ok));

  sysreset_ctl_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wbyte(wbyte),
    .stored(stored), .trig_ev(trig_ev), .keep_ev(keep_ev));

  sysreset_ctl_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .trig_ev(trig_ev), .req(rst_req));

  always_comb begin
    io_rdata = '0;
    if (rd_ok) io_rdata[REG_W-1:0] = stored;
    rst_type = stored[TYPE_BIT];
  end

  AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |-> io_rdata == '0); // R7
  AST_TRIG_READS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    io_rdata[TRIG_BIT] == 1'b0); // R5
  AST_TYPE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |-> io_rdata[TYPE_BIT] == rst_type); // R9
endmodule

// File: tb/sysreset_ctl_tb_top.sv
module sysreset_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [31:0] io_wdata = '0;
  logic [3:0]  io_be = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [31:0] io_rdata;
  logic        rst_req, rst_type;

  int total = 0, failed = 0;
  bit done = 0;
  logic [7:0] model = 8'h00;

  always #2 clk = ~clk;

  sysreset_ctl dut_i (.clk(clk), .rst_n(rst_n), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_be(io_be), .io_wr(io_wr), .io_rd(io_rd),
    .io_rdata(io_rdata), .rst_req(rst_req), .rst_type(rst_type));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write: request observed after the write edge, gone one edge later
  task automatic do_write(input logic [15:0] a, input logic [31:0] d,
                          input logic [3:0] be, input string req_tag);
    bit fires;
    fires = (a == 16'h0CF9) && be[0] && d[2];
    if ((a == 16'h0CF9) && be[0] && !d[2]) model = {6'b0, d[1], 1'b0};
    @(negedge clk);
    io_addr = a; io_wdata = d; io_be = be; io_wr = 1'b1;
    @(posedge clk); #1;
    check({req_tag, " req pulse"}, {31'b0, rst_req}, {31'b0, fires});
    check("R9 type", {31'b0, rst_type}, {31'b0, model[1]});
    @(negedge clk);
    io_wr = 1'b0; io_be = '0;
    @(posedge clk); #1;
    check("R2 pulse end", {31'b0, rst_req}, 32'd0);
  endtask

  task automatic do_read(input logic [15:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 check(tag, io_rdata, exp);
    io_rd = 1'b0;
    #1 check("R10 idle read", io_rdata, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R6 reset store", {31'b0, rst_type}, 32'd0);
    check("R6 reset req", {31'b0, rst_req}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    do_read(16'h0CF9, 32'd0, "R6 after reset");
    // R2 R3 R4 R5: exhaustive lane-0 values, with junk in upper lanes
    for (int v = 0; v < 256; v++) begin
      do_write(16'h0CF9, {8'hA5, 8'h5A, 8'hFF, 8'(v)}, 4'hF, v[2] ? "R2" : "R4");
      do_read(16'h0CF9, {24'b0, model}, v[2] ? "R3 held" : "R5 readback");
    end
    // R8: lane 0 disabled
    do_write(16'h0CF9, 32'h0, 4'hF, "R4");
    do_write(16'h0CF9, 32'h2, 4'h1, "R4");
    for (int b = 0; b < 16; b += 2) begin
      do_write(16'h0CF9, 32'h0000_0004, 4'(b), "R8");
      do_write(16'h0CF9, 32'h0000_0000, 4'(b), "R8");
      do_read(16'h0CF9, 32'h2, "R8 ignored");
    end
    // R1 R7: other addresses
    for (int k = 0; k < 16; k++) begin
      logic [15:0] a;
      a = 16'h0CF9 ^ (16'h1 << k);
      do_write(a, 32'h0000_0000, 4'hF, "R7");
      do_write(a, 32'h0000_0004, 4'hF, "R7");
      do_read(a, 32'd0, "R7 miss read");
      do_read(16'h0CF9, 32'h2, "R1 decode");
    end
    do_write(16'h0CF8, 32'h0000_0400, 4'hF, "R7");
    do_read(16'h0CF8, 32'd0, "R7 miss read");
    do_read(16'h0CF9, 32'h2, "R7 held");
    // R6: reset mid-run clears the stored byte
    @(negedge clk) rst_n = 1'b0;
    #1 check("R6 async clear", {31'b0, rst_type}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    model = 8'h00;
    do_read(16'h0CF9, 32'd0, "R6 reread");
    // back-to-back triggers: one pulse each
    @(negedge clk);
    io_addr = 16'h0CF9; io_wdata = 32'h4; io_be = 4'h1; io_wr = 1'b1;
    @(posedge clk); #1 check("R2 first", {31'b0, rst_req}, 32'd1);
    @(posedge clk); #1 check("R2 second", {31'b0, rst_req}, 32'd1);
    @(negedge clk) io_wr = 1'b0;
    @(posedge clk); #1 check("R2 end", {31'b0, rst_req}, 32'd0);
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule